// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a small synchronous memory that takes a command and an address on one clock edge and moves the data for that command two accepted edges later. Reads and writes use the same two-edge spacing. Because of that, reads and writes can be issued on consecutive accepted edges in any mix, and the data bus never needs an idle turnaround cycle. An active-low clock enable qualifies every edge. An edge on which the enable is high is ignored: nothing is sampled and nothing moves forward. During such an edge the output register keeps presenting the last read word.

The data word is 18 bits wide and split into two 9-bit byte lanes, with one active-low write enable per lane. The array is 64 words deep. Write data arrives on its own input port and read data leaves on its own output port. An output-enable flag stands in for tristate drivers.

A bus-state machine tracks what the data bus carries after each accepted edge. It has three states: `BUS_IDLE` (a bubble), `BUS_READ` (the output holds valid read data) and `BUS_WRITE` (write data is being absorbed). On every accepted edge the machine moves to the state that matches the command now leaving the second pipeline stage:
- a nop leads to `BUS_IDLE`
- a read leads to `BUS_READ`
- a write leads to `BUS_WRITE`

On an ignored edge it stays where it is. Reset sends it to `BUS_IDLE`.

Top module: `zbt_pipe_sram`

## Requirements
- R1: On a rising edge with `clk_en_n` high, the block samples no address, control or data, and no command moves forward in the pipeline.
- R2: A command is issued only when `sel_a_n`=0, `sel_b_n`=0, `sel_hi`=1 and `adv_ld_n`=0 on an accepted edge. In that case `rd_wr_n`=1 means read and 0 means write. Any other pin combination is a nop and leaves memory unchanged.
- R3: Read data for an address issued on accepted edge E appears on `dout`, with `dout_valid`=1, right after accepted edge E+2. Ignored edges in between add no delay.
- R4: While `clk_en_n` is high, `dout` and `dout_valid` keep their values.
- R5: Write data on `din` is sampled on the second accepted edge after the write's address edge. Reads and writes may be issued on consecutive accepted edges in any order.
- R6: Lane enables are sampled with the address. `we_n[0]`=0 updates bits 8:0 and `we_n[1]`=0 updates bits 17:9. A lane whose enable is 1 keeps its old contents.
- R7: `dout_oe` is 1 exactly when `dout_valid`=1 and `oe_n`=0. `oe_n` has no effect on writes.
- R8: A nop accepted on edge E makes `dout_valid` go to 0 right after accepted edge E+2, and `dout` keeps its last read value. A write leaving the pipeline also sets `dout_valid` to 0.
- R9: A read issued one or two accepted edges after a write to the same address returns the newly written, lane-merged word.
- R10: Synchronous active-high `rst` clears both pipeline stages, `dout_valid` and `dout`. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low edge qualifier |
| addr | input | 6 | Word address |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| adv_ld_n | input | 1 | Active-low load strobe |
| sel_a_n | input | 1 | Active-low select A |
| sel_b_n | input | 1 | Active-low select B |
| sel_hi | input | 1 | Active-high select |
| we_n | input | 2 | Active-low lane write enables |
| oe_n | input | 1 | Active-low output enable |
| din | input | 18 | Write data |
| dout | output | 18 | Read data register |
| dout_valid | output | 1 | `dout` holds data from a read |
| dout_oe | output | 1 | Output drivers would be on |

## Verification
On every cycle, the assertions check four things:
- the output freeze during ignored edges;
- that `dout_valid` follows the two-accepted-edge read delay, including bubbles from nops and writes;
- the gating of `dout_oe`;
- the reset clearing of `dout_valid`.

Some behaviours can only be shown by the bench's reference model running its scenarios. These are data correctness: lane merging, the placement of write data two accepted edges late with junk on `din` during stalls, read-after-write, and the proof that deselected commands leave memory untouched.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_e;
endpackage

// File: rtl/zbt_cmd_decode.sv
module zbt_cmd_decode
    import zbt_pkg::*;
(
    input  logic sel_a_n,
    input  logic sel_b_n,
    input  logic sel_hi,
    input  logic adv_ld_n,
    input  logic rd_wr_n,
    output op_e  op
);
    logic chip_on;

    always_comb begin
        chip_on = !sel_a_n && !sel_b_n && sel_hi;
        if (chip_on && !adv_ld_n) begin
            op = rd_wr_n ? OP_RD : OP_WR;
        end else begin
            op = OP_NOP;
        end
    end
endmodule

// File: rtl/zbt_pipe_ctrl.sv
module zbt_pipe_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  op_e               new_op,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [LANES-1:0]  new_we_n,
    output logic [ADDR_W-1:0] tail_addr,
    output logic [LANES-1:0]  tail_we_n,
    output logic              load_rd,
    output logic              commit_wr,
    output logic              bus_valid
);
    op_e               op1_q, op2_q;
    logic [ADDR_W-1:0] addr1_q, addr2_q;
    logic [LANES-1:0]  we1_q, we2_q;
    bus_e              bus_q, bus_d;

    // command stages: valid-carrying part
    always_ff @(posedge clk) begin
        if (rst) begin
            op1_q <= OP_NOP;
            op2_q <= OP_NOP;
        end else if (adv) begin
            op1_q <= new_op;
            op2_q <= op1_q;
        end
    end

    // command stages: payload, no reset needed
    always_ff @(posedge clk) begin
        if (adv) begin
            addr1_q <= new_addr;
            addr2_q <= addr1_q;
            we1_q   <= new_we_n;
            we2_q   <= we1_q;
        end
    end

    // bus-state register
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q <= BUS_IDLE;
        end else begin
            bus_q <= bus_d;
        end
    end

    // bus-state next-state logic
    always_comb begin
        bus_d = bus_q;
        if (adv) begin
            unique case (op2_q)
                OP_NOP:  bus_d = BUS_IDLE;
                OP_RD:   bus_d = BUS_READ;
                OP_WR:   bus_d = BUS_WRITE;
                default: bus_d = BUS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        tail_addr = addr2_q;
        tail_we_n = we2_q;
        load_rd   = adv && (op2_q == OP_RD) && !rst;
        commit_wr = adv && (op2_q == OP_WR) && !rst;
        bus_valid = (bus_q == BUS_READ);
    end
endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    wr_go,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [LANE_W*LANES-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANE_W*LANES-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_go && !lane_we_n[g]) begin
                cells[wr_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[rd_addr];
    end
endmodule

// File: rtl/zbt_pipe_sram.sv
module zbt_pipe_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    rd_wr_n,
    input  logic                    adv_ld_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_hi,
    input  logic [LANES-1:0]        we_n,
    input  logic                    oe_n,
    input  logic [LANE_W*LANES-1:0] din,
    output logic [LANE_W*LANES-1:0] dout,
    output logic                    dout_valid,
    output logic                    dout_oe
);
    localparam int DATA_W = LANE_W * LANES;

    op_e               issue_op;
    logic              adv;
    logic [ADDR_W-1:0] tail_addr;
    logic [LANES-1:0]  tail_we_n;
    logic              load_rd;
    logic              commit_wr;
    logic              bus_valid;
    logic [DATA_W-1:0] arr_rdata;

    assign adv = !clk_en_n;

    zbt_cmd_decode u_dec (
        .sel_a_n  (sel_a_n),
        .sel_b_n  (sel_b_n),
        .sel_hi   (sel_hi),
        .adv_ld_n (adv_ld_n),
        .rd_wr_n  (rd_wr_n),
        .op       (issue_op)
    );

    zbt_pipe_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .new_op    (issue_op),
        .new_addr  (addr),
        .new_we_n  (we_n),
        .tail_addr (tail_addr),
        .tail_we_n (tail_we_n),
        .load_rd   (load_rd),
        .commit_wr (commit_wr),
        .bus_valid (bus_valid)
    );

    zbt_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
        .clk       (clk),
        .wr_go     (commit_wr),
        .wr_addr   (tail_addr),
        .lane_we_n (tail_we_n),
        .wdata     (din),
        .rd_addr   (tail_addr),
        .rdata     (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (load_rd) begin
            dout <= arr_rdata;
        end
    end

    always_comb begin
        dout_valid = bus_valid;
        dout_oe    = bus_valid && !oe_n;
    end
endmodule

// File: rtl/zbt_pipe_sram_chk.sv
module zbt_pipe_sram_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en_n,
    input logic              rd_wr_n,
    input logic              adv_ld_n,
    input logic              sel_a_n,
    input logic              sel_b_n,
    input logic              sel_hi,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_valid,
    input logic              dout_oe
);
    logic rd_now, rd_s1, rd_s2, rd_out;

    assign rd_now = !sel_a_n && !sel_b_n && sel_hi && !adv_ld_n && rd_wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_s1  <= 1'b0;
            rd_s2  <= 1'b0;
            rd_out <= 1'b0;
        end else if (!clk_en_n) begin
            rd_s1  <= rd_now;
            rd_s2  <= rd_s1;
            rd_out <= rd_s2;
        end
    end

    // R4: frozen output while edges are ignored
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(dout) && $stable(dout_valid)));

    // R3 / R8: valid follows reads two accepted edges late, drops for nops and writes
    a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_out == dout_valid);

    // R7: drivers only with valid data
    a_r7_oe_needs_valid: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> dout_valid);

    // R7: enabled output is driven when data is valid
    a_r7_oe_follows_pin: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && !oe_n) |-> dout_oe);

    // R10: reset clears the valid flag
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> !dout_valid);
endmodule

bind zbt_pipe_sram zbt_pipe_sram_chk #(.DATA_W(LANE_W*LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_en_n   (clk_en_n),
    .rd_wr_n    (rd_wr_n),
    .adv_ld_n   (adv_ld_n),
    .sel_a_n    (sel_a_n),
    .sel_b_n    (sel_b_n),
    .sel_hi     (sel_hi),
    .oe_n       (oe_n),
    .dout       (dout),
    .dout_valid (dout_valid),
    .dout_oe    (dout_oe)
);

// File: tb/zbt_pipe_sram_tb.sv
`timescale 1ns/1ps
module zbt_pipe_sram_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        clk_en_n;
    logic [5:0]  addr;
    logic        rd_wr_n, adv_ld_n, sel_a_n, sel_b_n, sel_hi, oe_n;
    logic [1:0]  we_n;
    logic [17:0] din;
    logic [17:0] dout;
    logic        dout_valid, dout_oe;

    always #5 clk = ~clk;

    zbt_pipe_sram u_dut (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .addr(addr),
        .rd_wr_n(rd_wr_n), .adv_ld_n(adv_ld_n), .sel_a_n(sel_a_n),
        .sel_b_n(sel_b_n), .sel_hi(sel_hi), .we_n(we_n), .oe_n(oe_n),
        .din(din), .dout(dout), .dout_valid(dout_valid), .dout_oe(dout_oe)
    );

    // reference model state
    typedef struct { bit v; bit rd; int a; bit [1:0] we; } cmd_t;
    cmd_t        q[$];
    logic [17:0] ref_mem [64];
    logic [17:0] m_dout;
    bit          m_valid;
    int          n_chk = 0;
    int          n_bad = 0;
    string       req = "R10";
    bit          done = 0;

    task automatic model_edge();
        cmd_t c, e;
        if (rst) begin
            q.delete();
            m_valid = 0;
            m_dout = '0;
        end else if (!clk_en_n) begin
            c.v  = !sel_a_n && !sel_b_n && sel_hi && !adv_ld_n;
            c.rd = rd_wr_n;
            c.a  = int'(addr);
            c.we = we_n;
            q.push_back(c);
            m_valid = 0;
            if (q.size() > 2) begin
                e = q.pop_front();
                if (e.v && e.rd) begin
                    m_dout = ref_mem[e.a];
                    m_valid = 1;
                end else if (e.v) begin
                    if (!e.we[0]) ref_mem[e.a][8:0]  = din[8:0];
                    if (!e.we[1]) ref_mem[e.a][17:9] = din[17:9];
                end
            end
        end
    endtask

    task automatic compare();
        bit exp_oe;
        exp_oe = m_valid && !oe_n;
        n_chk++;
        if (dout !== m_dout || dout_valid !== m_valid || dout_oe !== exp_oe) begin
            n_bad++;
            $display("FAIL %s t=%0t dout=%h valid=%b oe=%b expected dout=%h valid=%b oe=%b",
                     req, $time, dout, dout_valid, dout_oe, m_dout, m_valid, exp_oe);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit cen, input bit rw, input bit ld_n,
                       input bit sa, input bit sb, input bit sh,
                       input int a, input bit [1:0] we, input bit oe,
                       input logic [17:0] d);
        clk_en_n = cen; rd_wr_n = rw; adv_ld_n = ld_n;
        sel_a_n = sa; sel_b_n = sb; sel_hi = sh;
        addr = a[5:0]; we_n = we; oe_n = oe; din = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic rd(input int a, input logic [17:0] d);
        cyc(0, 1, 0, 0, 0, 1, a, 2'b11, 0, d);
    endtask
    task automatic wr(input int a, input bit [1:0] we, input logic [17:0] d);
        cyc(0, 0, 0, 0, 0, 1, a, we, 0, d);
    endtask
    task automatic nop(input logic [17:0] d);
        cyc(0, 1, 0, 1, 0, 1, 0, 2'b11, 0, d);
    endtask
    task automatic stall(input int a, input logic [17:0] d);
        cyc(1, 0, 0, 0, 0, 1, a, 2'b00, 0, d);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1;
        @(negedge clk);
        req = "R10";
        repeat (3) cyc(0, 1, 0, 0, 0, 1, 0, 2'b11, 0, '0);
        rst = 0;

        // R5 fill: back-to-back writes, data two accepted edges behind
        req = "R5";
        for (int i = 0; i < 16; i++) wr(i, 2'b00, 18'(i * 4099 + 7));
        nop(18'(15 * 4099 + 7) - 18'(15 * 4099 + 7) + 18'(14 * 4099 + 7));
        nop(18'(15 * 4099 + 7));
        nop('0);

        // R3 back-to-back reads
        req = "R3";
        for (int i = 0; i < 8; i++) rd(i, '0);
        nop('0); nop('0); nop('0);

        // R1 and R4: stalls with junk pins between reads
        req = "R4";
        rd(3, '0); stall(9, 18'h3ffff); rd(4, '0); stall(10, 18'h15555);
        stall(11, 18'h2aaaa); rd(5, '0); stall(12, '1); nop('0); stall(0, '1); nop('0);
        req = "R1";
        wr(20, 2'b00, 18'h11111); stall(21, 18'h3ffff); nop(18'h00abc);
        stall(20, 18'h2aaaa); nop(18'h12345);
        rd(20, '0); rd(21, '0); nop('0); nop('0);

        // R2: deselected combinations and load strobe high must not write
        req = "R2";
        cyc(0, 0, 0, 1, 0, 1, 2, 2'b00, 0, '0);
        cyc(0, 0, 0, 0, 1, 1, 2, 2'b00, 0, '0);
        cyc(0, 0, 0, 0, 0, 0, 2, 2'b00, 0, 18'h3ffff);
        cyc(0, 0, 1, 0, 0, 1, 2, 2'b00, 0, 18'h3ffff);
        nop(18'h3ffff); nop(18'h3ffff);
        rd(2, '0); nop('0); nop('0);

        // R6: lane writes
        req = "R6";
        wr(30, 2'b00, '0); wr(31, 2'b00, '0); nop(18'h00000); nop(18'h00000);
        wr(30, 2'b10, '0); wr(31, 2'b01, '0); nop(18'h3fe55); nop(18'h0aa1ff);
        rd(30, '0); rd(31, '0); nop('0); nop('0);

        // R9: read right after write to same address
        req = "R9";
        wr(40, 2'b00, '0); rd(40, '0); nop(18'h1beef); nop('0); nop('0);
        wr(41, 2'b00, '0); nop('0); rd(41, 18'h0cafe); nop('0); nop('0);
        wr(41, 2'b01, '0); stall(41, '1); rd(41, '0); nop(18'h3f0f0); nop('0); nop('0);

        // R5 mixed order: write, read, write, read consecutively
        req = "R5";
        wr(50, 2'b00, '0); rd(1, '0); wr(51, 2'b00, 18'h2d2d2);
        rd(50, '0); rd(51, 18'h1e1e1); nop('0); nop('0); nop('0);

        // R7: output enable gating and no effect on writes
        req = "R7";
        rd(5, '0);
        cyc(0, 0, 0, 0, 0, 1, 52, 2'b00, 1, '0);
        cyc(0, 1, 0, 0, 0, 1, 52, 2'b11, 1, 18'h05a5a);
        cyc(0, 1, 1, 1, 1, 0, 0, 2'b11, 0, '0);
        cyc(0, 1, 1, 1, 1, 0, 0, 2'b11, 1, '0);
        nop('0); nop('0);

        // R8: bubbles between reads; dout holds last read
        req = "R8";
        rd(6, '0); nop('0); rd(7, '0); nop('0); nop('0); nop('0); nop('0);

        // R10: reset mid-stream clears valid and dout
        req = "R10";
        rd(8, '0); rd(9, '0); rd(10, '0);
        rst = 1; nop('0); rst = 0;
        nop('0); nop('0); nop('0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule